// File: doc/BRIEF.md
# Time-of-Day Counter with Selectable 12/24-Hour Readout

This block keeps the time of day for a chip that has a single system clock. An internal divider turns that clock into a one-cycle enable, once per second at the default setting. Seconds, minutes and hours are cascaded counters: the seconds carry steps the minutes, and the minutes carry steps the hours. Every register runs on the system clock. None of them is clocked by a derived clock.

Hours are held twice. A 24-hour counter and a 12-hour counter step together on the same minute carry, so each one always holds a valid count. A mode input only picks which of the two drives the hour digits, and changing it never disturbs the time. All six digits come out as BCD. A separate setting controller can add one to any single field. A one-cycle chime pulse marks each full hour that is reached by normal counting.

Top module: `tod_clock`

## Requirements
- R1: While `rst` is high at a clock edge, all counters return to midnight. The hour reads 00 when `mode_12h` is 0 and 12 when it is 1. Minutes and seconds read 00 and `chime` is 0. Counting starts again on the first tick after `rst` goes low.
- R2: The seconds digits count 00 to 59 in BCD (tens in `sec_tens`, units in `sec_ones`) and advance by one on each tick. At 59 a tick wraps them to 00 and carries into the minutes.
- R3: The minutes digits count 00 to 59 in BCD and advance only on a seconds carry. At 59 a seconds carry wraps them to 00 and carries into the hours.
- R4: With `mode_12h` = 0, the hour digits show a 24-hour count from 00 to 23. That count wraps from 23 to 00.
- R5: With `mode_12h` = 1, the hour digits show the sequence 12, 01, 02 … 11, then 12 again. Both hour counters always step together, so at any moment the 12-hour value equals the 24-hour value modulo 12, with 0 shown as 12. Changing the mode changes only the displayed hour.
- R6: A high `inc_sec`, `inc_min` or `inc_hour` at a clock edge adds one to that field, modulo its range, and never carries into the next field. If a field gets a request and a carry in the same cycle, it advances by one only.
- R7: `chime` is high for exactly one cycle, the cycle after a tick-driven carry takes minutes and seconds from 59:59 to 00:00. A field reaching 00 through an increment request gives no chime.
- R8: The divider raises its tick for one cycle in every `TICK_DIV` cycles. No counter advances in a cycle without a tick unless an increment request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset to midnight |
| mode_12h | input | 1 | 1 selects the 12-hour readout, 0 the 24-hour readout |
| inc_sec | input | 1 | Add one to the seconds field, without carry |
| inc_min | input | 1 | Add one to the minutes field, without carry |
| inc_hour | input | 1 | Add one to both hour counters |
| hr_tens | output | 4 | Hour tens digit (BCD) |
| hr_ones | output | 4 | Hour units digit (BCD) |
| min_tens | output | 4 | Minute tens digit (BCD) |
| min_ones | output | 4 | Minute units digit (BCD) |
| sec_tens | output | 4 | Second tens digit (BCD) |
| sec_ones | output | 4 | Second units digit (BCD) |
| chime | output | 1 | One-cycle pulse on each full hour reached by counting |

## Verification
A wrong digit, or a wrong wrap point in the seconds or minutes, shows up at the ports in the cycle after the faulty edge. The bench compares all six digits on every cycle of a full simulated day. If the two hour counters fall out of step, the display stays correct in one mode and goes wrong in the other. For that reason the bench flips `mode_12h` many times during the sweep, so a divergence shows up within a few thousand cycles at most. A misplaced chime or a carry leaking out of an adjustment differs from the arithmetic model at the first rollover or the first adjustment at a field's maximum. Random adjustment traffic reaches such a point within a few hundred cycles.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DIGIT_W = 4;
  localparam int HOUR_W  = 5;

  typedef logic [DIGIT_W-1:0] bcd_t;

  typedef struct packed {
    bcd_t tens;
    bcd_t ones;
  } bcd_pair_t;

  // Binary hour (0..23) to two BCD digits.
  function automatic bcd_pair_t hour_to_bcd(input logic [HOUR_W-1:0] v);
    bcd_pair_t r;
    if (v >= HOUR_W'(20)) begin
      r.tens = DIGIT_W'(2);
      r.ones = DIGIT_W'(v - HOUR_W'(20));
    end else if (v >= HOUR_W'(10)) begin
      r.tens = DIGIT_W'(1);
      r.ones = DIGIT_W'(v - HOUR_W'(10));
    end else begin
      r.tens = '0;
      r.ones = DIGIT_W'(v);
    end
    return r;
  endfunction
endpackage

// File: rtl/tod_tick_gen.sv
module tod_tick_gen #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || tick) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tod_bcd60.sv
module tod_bcd60
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cnt_step,
  input  logic adj_step,
  output bcd_t tens,
  output bcd_t ones,
  output logic carry
);
  localparam bcd_t ONES_TOP = DIGIT_W'(9);
  localparam bcd_t TENS_TOP = DIGIT_W'(5);

  logic at_top;
  assign at_top = (tens == TENS_TOP) && (ones == ONES_TOP);
  assign carry  = cnt_step && !adj_step && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      tens <= '0;
      ones <= '0;
    end else if (cnt_step || adj_step) begin
      if (ones == ONES_TOP) begin
        ones <= '0;
        tens <= (tens == TENS_TOP) ? '0 : tens + 1'b1;
      end else begin
        ones <= ones + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tod_wrap_ctr.sv
module tod_wrap_ctr #(
  parameter int W    = 5,
  parameter int LO   = 0,
  parameter int HI   = 23,
  parameter int INIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] val
);
  always_ff @(posedge clk) begin
    if (rst)       val <= W'(INIT);
    else if (step) val <= (val == W'(HI)) ? W'(LO) : val + 1'b1;
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int TICK_DIV = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_12h,
  input  logic       inc_sec,
  input  logic       inc_min,
  input  logic       inc_hour,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_ones,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic       chime
);
  logic tick, sec_carry, min_carry, hour_step;
  logic [HOUR_W-1:0] h24, h12, h_sel;
  bcd_pair_t h_bcd;

  tod_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  tod_bcd60 u_sec (
    .clk(clk), .rst(rst), .cnt_step(tick), .adj_step(inc_sec),
    .tens(sec_tens), .ones(sec_ones), .carry(sec_carry)
  );

  tod_bcd60 u_min (
    .clk(clk), .rst(rst), .cnt_step(sec_carry), .adj_step(inc_min),
    .tens(min_tens), .ones(min_ones), .carry(min_carry)
  );

  assign hour_step = min_carry || inc_hour;

  tod_wrap_ctr #(.W(HOUR_W), .LO(0), .HI(23), .INIT(0)) u_h24 (
    .clk(clk), .rst(rst), .step(hour_step), .val(h24)
  );

  tod_wrap_ctr #(.W(HOUR_W), .LO(1), .HI(12), .INIT(12)) u_h12 (
    .clk(clk), .rst(rst), .step(hour_step), .val(h12)
  );

  assign h_sel   = mode_12h ? h12 : h24;
  assign h_bcd   = hour_to_bcd(h_sel);
  assign hr_tens = h_bcd.tens;
  assign hr_ones = h_bcd.ones;

  always_ff @(posedge clk) begin
    if (rst) chime <= 1'b0;
    else     chime <= min_carry;
  end
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       mode_12h,
  input logic       inc_sec,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_ones,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones,
  input logic       chime
);
  // R1
  clear_on_rst_chk: assert property (@(posedge clk)
    rst |=> (sec_tens == 4'd0 && sec_ones == 4'd0 && min_tens == 4'd0 && min_ones == 4'd0 && !chime));

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tens <= 4'd5 && sec_ones <= 4'd9));

  // R3
  min_range_chk: assert property (@(posedge clk) disable iff (rst)
    (min_tens <= 4'd5 && min_ones <= 4'd9));

  // R4
  hour24_range_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_12h |-> ((hr_tens <= 4'd1 && hr_ones <= 4'd9) || (hr_tens == 4'd2 && hr_ones <= 4'd3)));

  // R5
  hour12_range_chk: assert property (@(posedge clk) disable iff (rst)
    mode_12h |-> ((hr_tens == 4'd0 && hr_ones >= 4'd1 && hr_ones <= 4'd9) || (hr_tens == 4'd1 && hr_ones <= 4'd2)));

  // R7
  chime_single_chk: assert property (@(posedge clk) disable iff (rst)
    chime |=> !chime);

  // R7
  chime_on_hour_chk: assert property (@(posedge clk) disable iff (rst)
    chime |-> (min_tens == 4'd0 && min_ones == 4'd0 && sec_tens == 4'd0 && sec_ones == 4'd0));

  // R8
  sec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !inc_sec) |=> ($stable(sec_ones) && $stable(sec_tens)));
endmodule

bind tod_clock tod_clock_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .mode_12h(mode_12h), .inc_sec(inc_sec),
  .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens), .min_ones(min_ones),
  .sec_tens(sec_tens), .sec_ones(sec_ones), .chime(chime)
);

// File: tb/tod_clock_tb.sv
module tod_clock_tb;
  logic clk = 1'b0;
  logic rst, mode_12h, inc_sec, inc_min, inc_hour, trst;
  logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;
  logic chime, tick3;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // model state
  int mh = 0, mm = 0, ms = 0;
  bit mchime = 0;

  always #5 clk = ~clk;

  tod_clock #(.TICK_DIV(1)) u_dut (
    .clk(clk), .rst(rst), .mode_12h(mode_12h),
    .inc_sec(inc_sec), .inc_min(inc_min), .inc_hour(inc_hour),
    .hr_tens(hr_tens), .hr_ones(hr_ones), .min_tens(min_tens), .min_ones(min_ones),
    .sec_tens(sec_tens), .sec_ones(sec_ones), .chime(chime)
  );

  tod_tick_gen #(.DIV(3)) u_tick3 (.clk(clk), .rst(trst), .tick(tick3));

  // Arithmetic model: with TICK_DIV=1 every cycle out of reset is a tick.
  always @(posedge clk) begin
    bit cs, cm;
    if (rst) begin
      mh = 0; mm = 0; ms = 0; mchime = 0;
    end else begin
      cs = 0; cm = 0;
      if (inc_sec) ms = (ms + 1) % 60;
      else begin cs = (ms == 59); ms = (ms + 1) % 60; end
      if (inc_min) mm = (mm + 1) % 60;
      else if (cs) begin cm = (mm == 59); mm = (mm + 1) % 60; end
      if (inc_hour || cm) mh = (mh + 1) % 24;
      mchime = cm;
    end
  end

  function automatic logic [23:0] expect_digits(int h, int m, int s, bit md);
    int hd;
    hd = md ? ((h % 12 == 0) ? 12 : h % 12) : h;
    return {4'(hd / 10), 4'(hd % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic compare(string tag, logic [23:0] got, logic [23:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_cycle(string tag);
    compare(tag, {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones},
            expect_digits(mh, mm, ms, mode_12h));
    compare("R7 chime", {23'd0, chime}, {23'd0, mchime});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1; trst = 1; mode_12h = 0; inc_sec = 0; inc_min = 0; inc_hour = 0;
    repeat (3) @(negedge clk);
    // R1: reset state in both modes
    check_cycle("R1 reset 24h");
    mode_12h = 1;
    @(negedge clk);
    check_cycle("R1 reset 12h");
    mode_12h = 0;
    rst = 0;

    // R2 R3 R4 R5 R7: one full day plus margin, mode flipped along the way
    for (int i = 0; i < 86410; i++) begin
      if (i % 4000 == 1999) mode_12h = ~mode_12h;
      @(negedge clk);
      check_cycle("R2 R3 R4 R5 day sweep");
    end

    // R6: random adjustment traffic on top of counting
    for (int i = 0; i < 6000; i++) begin
      inc_sec  = ($urandom % 3) == 0;
      inc_min  = ($urandom % 3) == 0;
      inc_hour = ($urandom % 5) == 0;
      if (i % 700 == 350) mode_12h = ~mode_12h;
      @(negedge clk);
      check_cycle("R6 adjust");
    end
    inc_sec = 0; inc_min = 0; inc_hour = 0;

    // R6: hold seconds adjust to run past 59 without a minute carry
    inc_sec = 1;
    for (int i = 0; i < 130; i++) begin
      @(negedge clk);
      check_cycle("R6 sec adjust no carry");
    end
    inc_sec = 0;

    // R1: reset mid-run, then counting resumes
    rst = 1;
    @(negedge clk);
    check_cycle("R1 mid reset");
    rst = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      check_cycle("R1 resume");
    end

    // R8: divider with DIV=3 pulses once every three cycles
    @(negedge clk);
    trst = 0;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      compare("R8 tick period", {23'd0, tick3}, {23'd0, 1'((k % 3) == 2)});
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule